// File: doc/BRIEF.md
# Programmable BERT Pattern Generator

This block produces a serial bit stream for bit-error-rate testing. A 32-bit shift register is rotated one place for each bit that a downstream consumer accepts. The register feeds back from two positions that can be chosen at run time, so the same hardware serves as a pseudo-random sequence generator of any length from 1 to 32 stages. The same register can also circulate a fixed word as a repeating pattern. A third mode ignores the programmed settings and produces the standard quasi-random signal sequence, a 20-stage sequence with long zero runs broken up.

The stream leaves through a valid/ready pair. `bit_valid` is high while `enable` is high and no load is in progress. A bit counts as transferred on a clock edge where both `bit_valid` and `bit_ready` are high, and only then does the register advance. While `bit_ready` is low, `bit_out` and the register hold their values, so the consumer may stall for any number of cycles and lose no bit. A load strobe reseeds the register from `seed`. The settings for mode, length and tap are read continuously and should be changed together with a load.

Top module: `bert_pattern_gen`

## Requirements
- R1: Asynchronous active-low reset sets every register stage to 1. `bit_valid` equals `enable && !load` at all times, so it is low while `enable` is low. The first bit after reset is 1.
- R2: The output stage is n = `len_sel` + 1 (stage k is register bit k-1). `bit_out` is stage n. On every transfer (`bit_valid && bit_ready`), stage k+1 takes the old stage k, and stage 1 takes the feedback bit.
- R3: With `repeat_mode` = 0 and `qrss_on` = 0 (PRBS), the feedback bit is stage n XOR stage y, where y = `tap_sel` + 1. The output then obeys s[t] = s[t-n] XOR s[t-y].
- R4: With `repeat_mode` = 1 and `qrss_on` = 0, the feedback bit is stage n alone. The stream repeats with period n, and `tap_sel` has no effect on it, even if it changes every cycle.
- R5: A clock edge with `load` high copies `seed` into the register (seed bit k-1 into stage k), so the first bit after a load is `seed[n-1]`. A load overrides a transfer in the same cycle, and `bit_valid` is low during the load cycle.
- R6: In PRBS mode, a load whose seed has stages 1..n all zero fills the register with ones instead. Repeat mode loads a zero seed unchanged.
- R7: With `qrss_on` = 1, the block ignores `repeat_mode`, `len_sel`, `tap_sel` and `seed`. It runs PRBS with n = 20 and y = 17, and a load fills the register with ones.
- R8: In QRSS mode, `bit_out` is forced to 1 whenever the current raw stage-20 bit and the 13 raw bits that follow it are all zero. The stream therefore never holds more than 13 zeros in a row.
- R9: While `bit_valid` is high and `bit_ready` is low, the register and `bit_out` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Allows bits to be offered |
| load | input | 1 | Reseed strobe, takes priority over shifting |
| seed | input | 32 | Seed or repeating pattern word |
| len_sel | input | 5 | Output/length stage select, n = value + 1 |
| tap_sel | input | 5 | Second feedback stage select, y = value + 1 |
| repeat_mode | input | 1 | 0 = PRBS, 1 = circulating pattern |
| qrss_on | input | 1 | Forces the fixed QRSS sequence |
| bit_ready | input | 1 | Consumer accepts the current bit |
| bit_out | output | 1 | Serial pattern bit |
| bit_valid | output | 1 | `bit_out` is offered |

## Verification
Two functions can meet in one cycle: a load, and a transfer that the consumer is ready to take. The bench pulses `load` while `enable` and `bit_ready` are high, and again while `bit_ready` is low. In both cases it expects `bit_valid` low for that cycle, and it expects the stream to restart from the new seed with no bit consumed from the old one. A behavioural reference computes every bit from the sequence recurrence, and the bench compares it with the output on every clock. This covers stalls under random back-pressure and the 13-zero limit of the QRSS suppression.

// File: rtl/bert_gen_pkg.sv
package bert_gen_pkg;

  typedef enum logic [1:0] {
    GEN_PRBS   = 2'd0,
    GEN_REPEAT = 2'd1,
    GEN_QRSS   = 2'd2
  } gen_mode_e;

  // QRSS overrides everything; otherwise the type select decides
  function automatic gen_mode_e pick_mode(input logic qrss, input logic rep);
    if (qrss) return GEN_QRSS;
    if (rep)  return GEN_REPEAT;
    return GEN_PRBS;
  endfunction

endpackage

// File: rtl/bert_tap_mux.sv
module bert_tap_mux
  import bert_gen_pkg::*;
#(
  parameter int REG_W    = 32,
  parameter int QRSS_LEN = 20,
  parameter int QRSS_TAP = 17,
  localparam int SEL_W   = $clog2(REG_W)
) (
  input  logic [REG_W-1:0] state,
  input  logic [SEL_W-1:0] len_sel,
  input  logic [SEL_W-1:0] tap_sel,
  input  gen_mode_e        mode,
  output logic             raw_bit,
  output logic             fb_bit,
  output logic [REG_W-1:0] len_mask
);

  logic [SEL_W-1:0] len_idx;
  logic [SEL_W-1:0] tap_idx;
  logic             tap_bit;

  always_comb begin
    if (mode == GEN_QRSS) begin
      len_idx = SEL_W'(QRSS_LEN - 1);
      tap_idx = SEL_W'(QRSS_TAP - 1);
    end else begin
      len_idx = len_sel;
      tap_idx = tap_sel;
    end
  end

  assign raw_bit  = state[len_idx];
  assign tap_bit  = state[tap_idx];
  assign fb_bit   = (mode == GEN_REPEAT) ? raw_bit : (raw_bit ^ tap_bit);
  // ones in stages 1..n
  assign len_mask = {REG_W{1'b1}} >> (SEL_W'(REG_W - 1) - len_idx);

endmodule

// File: rtl/bert_seed_prep.sv
module bert_seed_prep
  import bert_gen_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic [REG_W-1:0] seed,
  input  logic [REG_W-1:0] len_mask,
  input  gen_mode_e        mode,
  output logic [REG_W-1:0] load_val
);

  logic dead_seed;

  // a PRBS register with no one in its active stages never leaves zero
  assign dead_seed = ((seed & len_mask) == '0);

  always_comb begin
    unique case (mode)
      GEN_QRSS:   load_val = '1;
      GEN_PRBS:   load_val = dead_seed ? '1 : seed;
      default:    load_val = seed;
    endcase
  end

endmodule

// File: rtl/bert_zero_guard.sv
module bert_zero_guard
  import bert_gen_pkg::*;
#(
  parameter int GUARD_W = 14
) (
  input  logic [GUARD_W-1:0] window,
  input  logic               raw_bit,
  input  gen_mode_e          mode,
  output logic               out_bit
);

  logic quiet;

  // window holds the current raw bit and the ones that follow it
  assign quiet   = (window == '0);
  assign out_bit = ((mode == GEN_QRSS) && quiet) ? 1'b1 : raw_bit;

endmodule

// File: rtl/bert_pattern_gen.sv
module bert_pattern_gen
  import bert_gen_pkg::*;
#(
  parameter int REG_W    = 32,
  parameter int QRSS_LEN = 20,
  parameter int QRSS_TAP = 17,
  parameter int GUARD_W  = 14,
  localparam int SEL_W   = $clog2(REG_W),
  localparam int RUN_W   = $clog2(GUARD_W + 1) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             load,
  input  logic [REG_W-1:0] seed,
  input  logic [SEL_W-1:0] len_sel,
  input  logic [SEL_W-1:0] tap_sel,
  input  logic             repeat_mode,
  input  logic             qrss_on,
  input  logic             bit_ready,
  output logic             bit_out,
  output logic             bit_valid
);

  gen_mode_e        mode;
  logic [REG_W-1:0] shreg;
  logic [REG_W-1:0] load_val;
  logic [REG_W-1:0] len_mask;
  logic             raw_bit;
  logic             fb_bit;
  logic             fire;

  assign mode      = pick_mode(qrss_on, repeat_mode);
  assign bit_valid = enable && !load;
  assign fire      = bit_valid && bit_ready;

  bert_tap_mux #(
    .REG_W    (REG_W),
    .QRSS_LEN (QRSS_LEN),
    .QRSS_TAP (QRSS_TAP)
  ) u_tap_mux (
    .state    (shreg),
    .len_sel  (len_sel),
    .tap_sel  (tap_sel),
    .mode     (mode),
    .raw_bit  (raw_bit),
    .fb_bit   (fb_bit),
    .len_mask (len_mask)
  );

  bert_seed_prep #(
    .REG_W (REG_W)
  ) u_seed_prep (
    .seed     (seed),
    .len_mask (len_mask),
    .mode     (mode),
    .load_val (load_val)
  );

  // stages QRSS_LEN down to QRSS_LEN-GUARD_W+1 are the next raw output bits
  bert_zero_guard #(
    .GUARD_W (GUARD_W)
  ) u_zero_guard (
    .window  (shreg[QRSS_LEN-1 -: GUARD_W]),
    .raw_bit (raw_bit),
    .mode    (mode),
    .out_bit (bit_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    shreg <= '1;
    else if (load) shreg <= load_val;
    else if (fire) shreg <= {shreg[REG_W-2:0], fb_bit};
  end

  // zeros accepted in a row while in QRSS mode
  logic [RUN_W-1:0] zrun;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         zrun <= '0;
    else if (load || mode != GEN_QRSS)  zrun <= '0;
    else if (fire)                      zrun <= bit_out ? '0 : zrun + 1'b1;
  end

  a_r2_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !load |=> shreg[REG_W-1:1] == $past(shreg[REG_W-2:0]));

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid && !bit_ready |=> $stable(shreg));

  a_r5_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
    load && !qrss_on && repeat_mode |=> shreg == $past(seed));

  a_r6_live_state: assert property (@(posedge clk) disable iff (!rst_n)
    load && mode == GEN_PRBS |=> (shreg & $past(len_mask)) != '0);

  a_r7_qrss_fill: assert property (@(posedge clk) disable iff (!rst_n)
    load && qrss_on |=> shreg == '1);

  a_r8_zero_run: assert property (@(posedge clk) disable iff (!rst_n)
    zrun < RUN_W'(GUARD_W));

endmodule

// File: tb/test_bert_pattern_gen.sv
`timescale 1ns/1ps
module test_bert_pattern_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        load = 1'b0;
  logic [31:0] seed = '0;
  logic [4:0]  len_sel = 5'd31;
  logic [4:0]  tap_sel = 5'd27;
  logic        repeat_mode = 1'b0;
  logic        qrss_on = 1'b0;
  logic        bit_ready = 1'b0;
  logic        bit_out;
  logic        bit_valid;

  always #2.5 clk = ~clk;

  bert_pattern_gen i_bert_pattern_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .load        (load),
    .seed        (seed),
    .len_sel     (len_sel),
    .tap_sel     (tap_sel),
    .repeat_mode (repeat_mode),
    .qrss_on     (qrss_on),
    .bit_ready   (bit_ready),
    .bit_out     (bit_out),
    .bit_valid   (bit_valid)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // reference: bit sequence in output order, index p is the bit on offer
  bit q[$];
  int p, m_n, m_y;
  bit m_rep, m_qrss;
  int zr = 0, maxz = 0;
  bit rec = 1'b0;
  bit hist[$];

  function automatic bit mbit(int i);
    while (q.size() <= i) begin
      int k = q.size();
      q.push_back(m_rep ? q[k-m_n] : (q[k-m_n] ^ q[k-m_y]));
    end
    return q[i];
  endfunction

  function automatic bit model_out();
    bit any = 1'b0;
    if (!m_qrss) return mbit(p);
    for (int i = 0; i < 14; i++) any |= mbit(p + i);
    return any ? mbit(p) : 1'b1;
  endfunction

  function automatic void model_load(logic [31:0] s);
    longint msk;
    m_qrss = qrss_on;
    m_rep  = !qrss_on && repeat_mode;
    m_n    = qrss_on ? 20 : int'(len_sel) + 1;
    m_y    = qrss_on ? 17 : int'(tap_sel) + 1;
    msk    = (longint'(1) << m_n) - 1;
    if (qrss_on) s = '1;
    else if (!m_rep && ((s & msk[31:0]) == 32'd0)) s = '1;
    q.delete();
    for (int i = 31; i >= 0; i--) q.push_back(s[i]);
    p = 32 - m_n;
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial model_load('1);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  model_load('1);
    else if (load)               model_load(seed);
    else if (enable && bit_ready) p++;
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    logic ev, eb;
    if (rst_n && !done) begin
      ev = enable && !load;
      check(cur_req, bit_valid, ev, "bit_valid");
      if (ev) begin
        eb = model_out();
        check(cur_req, bit_out, eb, "bit_out");
        if (bit_ready) begin
          if (qrss_on) begin
            if (!bit_out) zr++; else zr = 0;
            if (zr > maxz) maxz = zr;
          end
          if (rec) hist.push_back(bit_out);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic run(int n, bit rnd);
    repeat (n) begin
      bit_ready = rnd ? ($urandom_range(0, 3) != 0) : 1'b1;
      step();
    end
    bit_ready = 1'b1;
  endtask

  task automatic do_load(logic [31:0] s, logic [4:0] ls, logic [4:0] ts, bit rep, bit qr);
    seed = s; len_sel = ls; tap_sel = ts; repeat_mode = rep; qrss_on = qr;
    load = 1'b1;
    #0.5;
    check("R5", bit_valid, 1'b0, "bit_valid during load");
    step();
    load = 1'b0;
    #0.5;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", bit_valid, 1'b0, "bit_valid in reset");
    rst_n = 1'b1;
    step();
    check("R1", bit_valid, 1'b0, "bit_valid with enable low");
    enable = 1'b1; bit_ready = 1'b1;
    #0.5;
    check("R1", bit_out, 1'b1, "first bit after reset");
    cur_req = "R2";
    run(40, 0);

    cur_req = "R3";
    do_load(32'h0000_005A, 5'd6, 5'd5, 0, 0);
    run(200, 0);
    do_load(32'h0000_4C21, 5'd14, 5'd13, 0, 0);
    run(300, 0);
    do_load(32'h8000_0001, 5'd31, 5'd21, 0, 0);
    run(300, 0);

    cur_req = "R9";
    do_load(32'h0012_3456, 5'd22, 5'd17, 0, 0);
    run(600, 1);

    cur_req = "R4";
    do_load(32'h0000_00A5, 5'd7, 5'd0, 1, 0);
    rec = 1'b1;
    repeat (80) begin tap_sel = 5'($urandom); step(); end
    rec = 1'b0;
    for (int i = 8; i < hist.size(); i++)
      check("R4", hist[i], hist[i-8], "period-8 repeat");

    cur_req = "R5";
    do_load(32'hDEAD_BEEF, 5'd11, 5'd4, 0, 0);
    check("R5", bit_out, seed[11], "first bit after load");
    run(50, 0);
    bit_ready = 1'b0;
    do_load(32'h0F0F_1234, 5'd9, 5'd2, 0, 0);
    check("R5", bit_out, seed[9], "first bit after stalled load");
    run(100, 1);

    cur_req = "R6";
    do_load(32'h0000_0F00, 5'd7, 5'd3, 0, 0);
    for (int i = 0; i < 8; i++) begin
      check("R6", bit_out, 1'b1, "ones substituted for dead seed");
      step();
    end
    run(100, 0);
    do_load(32'h0000_0000, 5'd9, 5'd0, 1, 0);
    for (int i = 0; i < 12; i++) begin
      check("R6", bit_out, 1'b0, "repeat mode keeps zero seed");
      step();
    end

    cur_req = "R7";
    do_load(32'h0000_0000, 5'd3, 5'd1, 1, 1);
    check("R7", bit_out, 1'b1, "qrss ignores seed");
    run(200, 0);

    cur_req = "R8";
    run(120000, 0);
    run(2000, 1);
    checks++;
    if (maxz > 13) begin
      errors++;
      $display("FAIL R8 longest zero run: actual %0d expected at most 13", maxz);
    end
    finish_up();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog during %s: actual timeout expected completion", cur_req);
      finish_up();
    end
  end

endmodule